// File: doc/BRIEF.md
# Banked Internal Data RAM with Bit Window and Stack

This block is the 128-byte internal data memory of a small 8-bit controller. One storage array is reached in three ways. A byte port reads or writes any byte by a 7-bit direct address. In register mode, the same byte port builds the address from a 3-bit register number and the 2-bit bank select taken from the status word. A bit port sets, clears or reads single bits in the bit-addressable window at bytes 20h–2Fh. A stack port pushes and pops through an internal stack pointer.

Only one request is served per clock. When several arrive in the same cycle, a fixed precedence picks the winner and the other requests have no effect. Read results are registered, so they appear one clock after the request and then hold until the next read.

Top module: `iram_banked`

## Requirements
- R1: A byte write (byte_req=1, byte_wr=1, reg_mode=0) stores byte_wdata at byte_addr, for any address 00h–7Fh. A byte read (byte_wr=0) places the stored byte on rd_data on the clock after the request. rd_data holds its value in cycles with no byte read and no pop.
- R2: In register mode (reg_mode=1), the byte address is bank_sel*8 + reg_num, and byte_addr is ignored.
- R3: The four bank_sel values 0, 1, 2 and 3 place R0–R7 at 00h–07h, 08h–0Fh, 10h–17h and 18h–1Fh.
- R4: Bit address N selects bit N mod 8 (bit 0 is the LSB) of byte 20h + N/8. A bit read (bit_op=01) places that bit on bit_rdata on the next clock. After 20h is written with FFh, bit addresses 00h–07h read as 1.
- R5: A bit clear (bit_op=10) or bit set (bit_op=11) changes the selected bit in one cycle and leaves the other 7 bits of that byte unchanged. bit_op=00 does nothing.
- R6: After reset, sp is 07h, rd_data and bit_rdata are 0, and every byte reads as 00h.
- R7: A push increments sp first and then writes push_data at the new sp, so the first push after reset lands at 08h.
- R8: A pop puts the byte at the current sp on rd_data on the next clock and then decrements sp.
- R9: sp wraps modulo 128: a push at 7Fh goes to 00h, and a pop at 00h leaves 7Fh.
- R10: Precedence is push, then pop, then byte port, then bit port. A request that loses leaves the memory, sp, rd_data and bit_rdata as if it had not been made.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| bank_sel | input | 2 | Register bank select from the status word |
| byte_req | input | 1 | Byte port request |
| byte_wr | input | 1 | 1 = write, 0 = read |
| reg_mode | input | 1 | 1 = address from bank_sel and reg_num |
| byte_addr | input | 7 | Direct byte address |
| reg_num | input | 3 | Working register number |
| byte_wdata | input | 8 | Byte write data |
| bit_op | input | 2 | 00 none, 01 read, 10 clear, 11 set |
| bit_addr | input | 7 | Bit address in the window |
| push | input | 1 | Push request |
| pop | input | 1 | Pop request |
| push_data | input | 8 | Data to push |
| rd_data | output | 8 | Registered byte read or pop result |
| bit_rdata | output | 1 | Registered bit read result |
| sp | output | 7 | Stack pointer |

## Verification
The array is first filled through direct addressing with a pattern unique to each address, and read back at scattered addresses. This separates address decoding faults from data faults. Register-mode writes in all four banks, read back through direct addresses, show whether bank and register bits land in the right order. Bit reads after a FFh byte write, followed by single-bit set and clear with byte read-back, test the N/8 and N mod 8 mapping and whether neighbouring bits survive the update. Push/pop runs across both ends of the pointer range, plus cycles with colliding requests, test pre-increment, post-decrement, wrap-around and which request wins.

// File: rtl/iram_banked.sv
module iram_banked #(
  parameter int AW = 7,
  parameter int DW = 8,
  parameter logic [AW-1:0] SP_INIT = 7'h07,
  parameter logic [AW-1:0] BIT_BASE = 7'h20
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [1:0]    bank_sel,
  input  logic          byte_req,
  input  logic          byte_wr,
  input  logic          reg_mode,
  input  logic [AW-1:0] byte_addr,
  input  logic [2:0]    reg_num,
  input  logic [DW-1:0] byte_wdata,
  input  logic [1:0]    bit_op,
  input  logic [AW-1:0] bit_addr,
  input  logic          push,
  input  logic          pop,
  input  logic [DW-1:0] push_data,
  output logic [DW-1:0] rd_data,
  output logic          bit_rdata,
  output logic [AW-1:0] sp
);
  localparam int DEPTH = 1 << AW;

  logic [DW-1:0] mem [DEPTH];

  wire           pop_win  = pop && !push;
  wire           byte_win = byte_req && !push && !pop;
  wire           bit_win  = (bit_op != 2'b00) && !push && !pop && !byte_req;
  wire [AW-1:0]  sp_next  = sp + 1'b1;
  wire [AW-1:0]  b_addr   = reg_mode ? AW'({bank_sel, reg_num}) : byte_addr;
  wire [AW-1:0]  bb       = BIT_BASE + AW'(bit_addr[AW-1:3]);
  wire [2:0]     bk       = bit_addr[2:0];
  wire [DW-1:0]  bb_byte  = mem[bb];

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      for (int i = 0; i < DEPTH; i++) mem[i] <= '0;
      sp        <= SP_INIT;
      rd_data   <= '0;
      bit_rdata <= 1'b0;
    end else if (push) begin
      sp           <= sp_next;
      mem[sp_next] <= push_data;
    end else if (pop) begin
      rd_data <= mem[sp];
      sp      <= sp - 1'b1;
    end else if (byte_req) begin
      if (byte_wr) mem[b_addr] <= byte_wdata;
      else         rd_data     <= mem[b_addr];
    end else if (bit_op == 2'b01) begin
      bit_rdata <= bb_byte[bk];
    end else if (bit_op[1]) begin
      mem[bb][bk] <= bit_op[0];
    end
  end

  a_r7_push_preinc: assert property (@(posedge clk) disable iff (!rst_n)
    push |=> (sp == $past(sp_next)) && (mem[sp] == $past(push_data)));

  a_r8_pop_postdec: assert property (@(posedge clk) disable iff (!rst_n)
    pop_win |=> (sp == $past(sp) - 1'b1) && (rd_data == $past(mem[sp])));

  a_r10_sp_idle: assert property (@(posedge clk) disable iff (!rst_n)
    (!push && !pop) |=> $stable(sp));

  a_r5_bit_others: assert property (@(posedge clk) disable iff (!rst_n)
    (bit_win && bit_op[1]) |=>
      (((mem[$past(bb)] ^ $past(bb_byte)) & ~(8'd1 << $past(bk))) == 8'd0) &&
      (mem[$past(bb)][$past(bk)] == $past(bit_op[0])));

  a_r10_byte_loses: assert property (@(posedge clk) disable iff (!rst_n)
    (byte_req && !byte_wr && (push || pop)) |=> $stable(bit_rdata));
endmodule

// File: tb/iram_banked_test.sv
`timescale 1ns/1ps
module iram_banked_test;
  logic clk = 0, rst_n = 0;
  logic [1:0] bank_sel = 0, bit_op = 0;
  logic byte_req = 0, byte_wr = 0, reg_mode = 0, push = 0, pop = 0;
  logic [6:0] byte_addr = 0, bit_addr = 0;
  logic [2:0] reg_num = 0;
  logic [7:0] byte_wdata = 0, push_data = 0;
  logic [7:0] rd_data;
  logic bit_rdata;
  logic [6:0] sp;

  int ram [128];
  int m_sp = 7, m_rd = 0, m_bit = 0;
  int n_cmp = 0, n_bad = 0;
  string tag = "R6";

  always #10 clk = ~clk;

  iram_banked uut (.clk, .rst_n, .bank_sel, .byte_req, .byte_wr, .reg_mode,
    .byte_addr, .reg_num, .byte_wdata, .bit_op, .bit_addr, .push, .pop,
    .push_data, .rd_data, .bit_rdata, .sp);

  task automatic model();
    int a, b, k;
    if (!rst_n) begin
      foreach (ram[i]) ram[i] = 0;
      m_sp = 7; m_rd = 0; m_bit = 0;
    end else if (push) begin
      m_sp = (m_sp + 1) % 128; ram[m_sp] = push_data;
    end else if (pop) begin
      m_rd = ram[m_sp]; m_sp = (m_sp + 127) % 128;
    end else if (byte_req) begin
      a = reg_mode ? bank_sel * 8 + reg_num : byte_addr;
      if (byte_wr) ram[a] = byte_wdata; else m_rd = ram[a];
    end else if (bit_op != 0) begin
      b = 32 + bit_addr / 8; k = bit_addr % 8;
      if (bit_op == 1) m_bit = (ram[b] >> k) & 1;
      else if (bit_op == 3) ram[b] = ram[b] | (1 << k);
      else ram[b] = ram[b] & ~(1 << k) & 255;
    end
  endtask

  task automatic cyc();
    @(posedge clk); model();
    @(negedge clk);
    n_cmp++;
    if (rd_data !== m_rd[7:0] || bit_rdata !== m_bit[0] || sp !== m_sp[6:0]) begin
      n_bad++;
      $display("FAIL %s: rd=%h bit=%b sp=%h expected rd=%h bit=%b sp=%h",
               tag, rd_data, bit_rdata, sp, m_rd[7:0], m_bit[0], m_sp[6:0]);
    end
    {byte_req, byte_wr, reg_mode, push, pop, bit_op} = '0;
  endtask

  task automatic bw(input int a, input int d);
    byte_req = 1; byte_wr = 1; byte_addr = a[6:0]; byte_wdata = d[7:0]; cyc();
  endtask
  task automatic br(input int a);
    byte_req = 1; byte_addr = a[6:0]; cyc(); cyc();
  endtask
  task automatic bitop(input int op, input int a);
    bit_op = op[1:0]; bit_addr = a[6:0]; cyc(); cyc();
  endtask
  task automatic psh(input int d);
    push = 1; push_data = d[7:0]; cyc();
  endtask
  task automatic pp();
    pop = 1; cyc(); cyc();
  endtask

  initial begin
    #200000000;
    n_bad++;
    $display("FAIL watchdog: run did not finish, expected completion");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

  initial begin
    @(negedge clk); cyc(); cyc();
    rst_n = 1;
    tag = "R6"; cyc(); br(7'h55); br(7'h00);
    tag = "R1";
    for (int i = 0; i < 128; i++) bw(i, (i * 37 + 11) & 255);
    for (int i = 0; i < 128; i += 9) br(i);
    br(127);
    tag = "R2";
    for (int b = 0; b < 4; b++)
      for (int r = 0; r < 8; r++) begin
        byte_req = 1; byte_wr = 1; reg_mode = 1; bank_sel = b[1:0];
        reg_num = r[2:0]; byte_addr = 7'h7F; byte_wdata = 8'(b * 16 + r + 128);
        cyc();
      end
    tag = "R3";
    for (int i = 0; i < 32; i += 3) br(i);
    br(7'h7F);
    bank_sel = 2; reg_num = 5; byte_req = 1; reg_mode = 1; cyc(); cyc();
    tag = "R4";
    bw(7'h20, 8'hFF);
    for (int n = 0; n < 8; n++) bitop(1, n);
    bw(7'h2F, 8'h00); bitop(1, 7'h7F); bitop(1, 7'h23);
    tag = "R5";
    bitop(2, 7'h03); br(7'h20);
    bitop(3, 7'h7E); br(7'h2F);
    bitop(2, 7'h44); br(7'h28);
    bitop(3, 7'h44); br(7'h28); bitop(1, 7'h44);
    bitop(0, 7'h05); br(7'h20);
    tag = "R7";
    rst_n = 0; cyc(); rst_n = 1; cyc();
    psh(8'hA1); br(7'h08); psh(8'hB2); psh(8'hC3); br(7'h0A);
    tag = "R8";
    pp(); pp(); pp(); pp();
    tag = "R9";
    for (int i = 0; i < 8; i++) pp();
    psh(8'h5A); psh(8'h6B); br(7'h00);
    for (int i = 0; i < 3; i++) pp();
    tag = "R10";
    push = 1; pop = 1; push_data = 8'h77; byte_req = 1; byte_wr = 1;
    byte_addr = 7'h30; byte_wdata = 8'hEE; bit_op = 3; bit_addr = 7'h10; cyc();
    br(7'h30); br(7'h22);
    pop = 1; byte_req = 1; byte_addr = 7'h31; cyc(); cyc();
    byte_req = 1; byte_wr = 1; byte_addr = 7'h22; byte_wdata = 8'h00;
    bit_op = 3; bit_addr = 7'h10; cyc(); br(7'h22);
    byte_req = 1; byte_addr = 7'h40; bit_op = 1; bit_addr = 7'h7E; cyc(); cyc();
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end
endmodule